// File: doc/BRIEF.md
# Montgomery Modular Product Unit

This unit computes Montgomery products for modular exponentiation with an odd modulus M. It holds an accumulator A. Each multiply command replaces A with P = (A·X + Q·M) / R. Here R = 2^(OPW+GUARD), X is the selected multiplier and Q is the quotient the algorithm builds bit by bit. The multiplier is scanned one bit per cycle, least significant bit first. The running sum is kept as a sum vector and a carry vector. Each cycle it absorbs the terms x_i·A and q_i·M through two carry-save stages and is then halved.

No comparison against M is made and nothing is subtracted. When every input is below 2M, the result also stays below 2M, so a host can chain squarings and multiplies indefinitely. The host brings the result into the range below M once, at the end. After the last bit step, a settle phase adds the sum and carry vectors repeatedly until the carry vector is zero. A carry-free result therefore completes in one cycle instead of after a full-width ripple.

The host writes the multiplier B, a stored cube B3 and the modulus through a 32-bit word port. It issues load, square and multiply commands, waits while `busy` is high, and drains the result through a 32-bit read port.

Top module: `mont_prod_unit`

## Requirements
- R1: A MULB command (cmd_op = 2) replaces the accumulator with the value of the recurrence p0 = 0, p(i+1) = (p(i) + x_i·A + q_i·M) / 2 over i = 0 … OPW+GUARD−1. Here x = B, and q_i is chosen so that the sum is even.
- R2: A SQUARE command (cmd_op = 1) runs the same recurrence with the multiplier equal to the current accumulator.
- R3: A MULB3 command (cmd_op = 3) runs the same recurrence with the multiplier equal to the B3 register.
- R4: A LOAD command (cmd_op = 0) copies B, zero-extended, into both the accumulator and the read buffer within one cycle, and `busy` stays low.
- R5: No final subtraction is made. Results equal to or above M are delivered unchanged, and with inputs below 2M every result is below 2M.
- R6: A write with wr_en high shifts wr_data into the top word of the register selected by wr_tgt (0 = B, 1 = B3, 2 = modulus; 3 selects nothing). The first word written thus ends up least significant once OPW/32 words have been written.
- R7: A read with rd_en high while idle puts the low 32 bits of the read buffer on rd_data on the next cycle and shifts the buffer right by 32 with zero fill. After ceil((OPW+GUARD+2)/32) reads, only zeros remain.
- R8: `busy` rises in the cycle after a multiply command is accepted. It stays high for at least OPW+GUARD+1 and at most 2·OPW+2·GUARD+3 cycles.
- R9: While `busy` is high, commands, modulus writes and reads are ignored: the result, the modulus and rd_data are unaffected.
- R10: A completed multiply leaves its result in the accumulator, where it is the operand of the next command.
- R11: After reset, `busy` is low, rd_data is zero and the read buffer holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_op | input | 2 | 0 load, 1 square, 2 multiply by B, 3 multiply by B3 |
| wr_en | input | 1 | Operand word write strobe |
| wr_tgt | input | 2 | Write target: 0 B, 1 B3, 2 modulus |
| wr_data | input | 32 | Operand word |
| rd_en | input | 1 | Result word read strobe |
| rd_data | output | 32 | Registered result word |
| busy | output | 1 | High during multiply and carry settling |

## Verification
If a quotient bit is computed wrongly or one of the carry-save stages drops a carry, the result word read back after the next command is wrong. Chaining carries the error into every later product, so a single mis-step shows at the read port within one command. A settle phase that stops too early returns a value that differs from the arithmetic recurrence. A settle phase that never stops keeps `busy` high past its bound. Sweeps over several moduli, including the smallest and extreme odd values, with long chains of mixed commands, compare each read-back word against an integer model of the recurrence.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_SQUARE = 2'd1,
    OP_MULB   = 2'd2,
    OP_MULB3  = 2'd3
  } mpu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_SETL = 2'd2
  } mpu_state_e;

  localparam logic [1:0] TGT_B   = 2'd0;
  localparam logic [1:0] TGT_B3  = 2'd1;
  localparam logic [1:0] TGT_MOD = 2'd2;
endpackage

// File: rtl/mpu_operand_bank.sv
module mpu_operand_bank #(
  parameter int OPW = 256,
  parameter int WW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [1:0]     wr_tgt,
  input  logic [WW-1:0]  wr_data,
  input  logic           lock_mod,
  output logic [OPW-1:0] b_q,
  output logic [OPW-1:0] b3_q,
  output logic [OPW-1:0] mod_q
);
  localparam int NREG = 3;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [OPW-1:0] r;
    logic           hit;
    assign hit = wr_en && (wr_tgt == 2'(g)) && !(lock_mod && (g == 2));
    if (OPW > WW) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)      r <= '0;
        else if (hit) r <= {wr_data, r[OPW-1:WW]};
      end
    end else begin : g_word
      always_ff @(posedge clk) begin
        if (rst)      r <= '0;
        else if (hit) r <= OPW'(wr_data);
      end
    end
  end

  assign b_q   = g_reg[0].r;
  assign b3_q  = g_reg[1].r;
  assign mod_q = g_reg[2].r;
endmodule

// File: rtl/mpu_bit_step.sv
module mpu_bit_step #(
  parameter int W = 262
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] m_in,
  input  logic         xbit,
  output logic [W-1:0] s_out,
  output logic [W-1:0] c_out
);
  logic [W-1:0] add_a, add_m, s1, c1, s2, c2;
  logic         qbit;

  always_comb begin
    add_a = xbit ? a_in : '0;
    s1    = s_in ^ c_in ^ add_a;
    c1    = ((s_in & c_in) | (s_in & add_a) | (c_in & add_a)) << 1;
    qbit  = s1[0];
    add_m = qbit ? m_in : '0;
    s2    = s1 ^ c1 ^ add_m;
    c2    = ((s1 & c1) | (s1 & add_m) | (c1 & add_m)) << 1;
    s_out = s2 >> 1;
    c_out = c2 >> 1;
  end
endmodule

// File: rtl/mpu_carry_settle.sv
module mpu_carry_settle #(
  parameter int W = 262
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  output logic [W-1:0] s_out,
  output logic [W-1:0] c_out,
  output logic         settled
);
  always_comb begin
    s_out   = s_in ^ c_in;
    c_out   = (s_in & c_in) << 1;
    settled = (c_in == '0);
  end
endmodule

// File: rtl/mont_prod_unit.sv
module mont_prod_unit #(
  parameter int OPW   = 256,
  parameter int GUARD = 4,
  parameter int WW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          wr_en,
  input  logic [1:0]    wr_tgt,
  input  logic [WW-1:0] wr_data,
  input  logic          rd_en,
  output logic [WW-1:0] rd_data,
  output logic          busy
);
  import mpu_pkg::*;

  localparam int RBITS  = OPW + GUARD;
  localparam int ACCW   = OPW + GUARD + 2;
  localparam int NWORDS = (ACCW + WW - 1) / WW;
  localparam int BUFW   = NWORDS * WW;
  localparam int CW     = $clog2(RBITS + 1);

  mpu_state_e       st_q;
  logic [ACCW-1:0]  acc_q, s_q, c_q;
  logic [RBITS-1:0] x_q;
  logic [CW-1:0]    cnt_q;
  logic [BUFW-1:0]  pbuf_q;
  logic [WW-1:0]    rd_data_q;

  logic [OPW-1:0]   b_q, b3_q, mod_q;
  logic [ACCW-1:0]  st_s, st_c, cs_s, cs_c;
  logic             cs_done;

  mpu_operand_bank #(.OPW(OPW), .WW(WW)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_data(wr_data),
    .lock_mod(st_q != ST_IDLE), .b_q(b_q), .b3_q(b3_q), .mod_q(mod_q)
  );

  mpu_bit_step #(.W(ACCW)) u_step (
    .s_in(s_q), .c_in(c_q), .a_in(acc_q), .m_in(ACCW'(mod_q)),
    .xbit(x_q[0]), .s_out(st_s), .c_out(st_c)
  );

  mpu_carry_settle #(.W(ACCW)) u_settle (
    .s_in(s_q), .c_in(c_q), .s_out(cs_s), .c_out(cs_c), .settled(cs_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      acc_q     <= '0;
      s_q       <= '0;
      c_q       <= '0;
      x_q       <= '0;
      cnt_q     <= '0;
      pbuf_q    <= '0;
      rd_data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (rd_en) begin
            rd_data_q <= pbuf_q[WW-1:0];
            pbuf_q    <= pbuf_q >> WW;
          end
          if (cmd_valid) begin
            s_q   <= '0;
            c_q   <= '0;
            cnt_q <= '0;
            case (mpu_op_e'(cmd_op))
              OP_LOAD: begin
                acc_q  <= ACCW'(b_q);
                pbuf_q <= BUFW'(b_q);
              end
              OP_SQUARE: begin
                x_q  <= RBITS'(acc_q);
                st_q <= ST_MUL;
              end
              OP_MULB: begin
                x_q  <= RBITS'(b_q);
                st_q <= ST_MUL;
              end
              default: begin
                x_q  <= RBITS'(b3_q);
                st_q <= ST_MUL;
              end
            endcase
          end
        end
        ST_MUL: begin
          s_q   <= st_s;
          c_q   <= st_c;
          x_q   <= x_q >> 1;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(RBITS - 1)) st_q <= ST_SETL;
        end
        default: begin
          if (cs_done) begin
            acc_q  <= s_q;
            pbuf_q <= BUFW'(s_q);
            st_q   <= ST_IDLE;
          end else begin
            s_q <= cs_s;
            c_q <= cs_c;
          end
        end
      endcase
    end
  end

  assign rd_data = rd_data_q;
  assign busy    = (st_q != ST_IDLE);
endmodule

// File: rtl/mpu_checker.sv
module mpu_checker #(
  parameter int OPW   = 256,
  parameter int GUARD = 4,
  parameter int WW    = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic          rd_en,
  input logic [WW-1:0] rd_data,
  input logic          busy,
  input logic [OPW-1:0] mod_q
);
  localparam int LIMIT = 2 * OPW + 2 * GUARD + 3;
  localparam int BCW   = $clog2(LIMIT + 2) + 1;

  logic [BCW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op != 2'd0) |=> busy);

  // R4
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == 2'd0) |=> !busy);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> $stable(rd_data));

  // R9
  mod_lock_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mod_q));

  // R8
  always_ff @(posedge clk) begin
    if (!rst) begin
      busy_len_chk: assert (busy_cnt <= BCW'(LIMIT));
    end
  end
endmodule

bind mont_prod_unit mpu_checker #(.OPW(OPW), .GUARD(GUARD), .WW(WW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .rd_en(rd_en),
  .rd_data(rd_data), .busy(busy), .mod_q(mod_q)
);

// File: tb/sim_mont_prod_unit.sv
module sim_mont_prod_unit;
  localparam int CLK_PERIOD = 10;
  localparam int OPW   = 32;
  localparam int GUARD = 4;
  localparam int RBITS = OPW + GUARD;
  localparam int ACCW  = OPW + GUARD + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_tgt = 2'd0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        busy;

  int nchk = 0;
  int nfail = 0;
  logic [63:0] acc_m, b_m, b3_m, mod_m;
  logic [31:0] seed = 32'h1234_5678;
  bit seen_ge_m = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mont_prod_unit #(.OPW(OPW), .GUARD(GUARD), .WW(32)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mont(input logic [63:0] a, input logic [63:0] x, input logic [63:0] m);
    logic [63:0] p = '0;
    for (int i = 0; i < RBITS; i++) begin
      if (x[i]) p = p + a;
      if (p[0]) p = p + m;
      p = p >> 1;
    end
    return p;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic wr(input logic [1:0] tgt, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_tgt = tgt; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic read_result(output logic [63:0] v);
    logic [31:0] w0, w1;
    rd(w0);
    rd(w1);
    v = {w1, w0};
  endtask

  task automatic run_op(input logic [1:0] op, input string req);
    logic [63:0] got, exp;
    int n;
    case (op)
      2'd1: exp = mont(acc_m, acc_m, mod_m);
      2'd2: exp = mont(acc_m, b_m, mod_m);
      default: exp = mont(acc_m, b3_m, mod_m);
    endcase
    cmd(op);
    wait_idle(n);
    chk((n >= RBITS + 1) && (n <= 2 * RBITS + 3 + 0 * ACCW), "R8 busy length", 64'(n), 64'(RBITS + 1));
    read_result(got);
    chk(got == exp, req, got, exp);
    chk(got < 2 * mod_m, "R5 below 2M", got, 2 * mod_m);
    if (got >= mod_m) seen_ge_m = 1'b1;
    acc_m = exp;
  endtask

  function automatic logic [31:0] mod_of(input int i);
    case (i)
      0: return 32'd3;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0001;
      3: return 32'h0001_0001;
      default: return 32'h9E37_79B1;
    endcase
  endfunction

  initial begin
    logic [31:0] w;
    logic [63:0] v, exp;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(busy == 1'b0, "R11 busy after reset", 64'(busy), 0);
    chk(rd_data == 32'd0, "R11 rd_data after reset", 64'(rd_data), 0);
    rd(w);
    chk(w == 32'd0, "R11 buffer after reset", 64'(w), 0);

    for (int mi = 0; mi < 5; mi++) begin
      mod_m = 64'(mod_of(mi));
      wr(2'd2, mod_m[31:0]);
      seed = nxt(seed);
      b3_m = 64'(seed) % mod_m;
      wr(2'd1, b3_m[31:0]);
      // R6 last word written to B is the operand; R4 load copies it
      wr(2'd0, 32'hDEAD_BEEF);
      seed = nxt(seed);
      b_m = 64'(seed) % mod_m;
      wr(2'd0, b_m[31:0]);
      cmd(2'd0);
      chk(busy == 1'b0, "R4 load leaves busy low", 64'(busy), 0);
      read_result(v);
      chk(v == b_m, "R4 R6 load value", v, b_m);
      // R7 buffer drained to zero
      rd(w);
      chk(w == 32'd0, "R7 zero fill", 64'(w), 0);
      acc_m = b_m;
      for (int k = 0; k < 40; k++) begin
        case (k % 3)
          0: run_op(2'd1, "R2 R10 square");
          1: begin
            seed = nxt(seed);
            b_m = 64'(seed) % mod_m;
            wr(2'd0, b_m[31:0]);
            run_op(2'd2, "R1 R10 multiply by B");
          end
          default: run_op(2'd3, "R3 multiply by B3");
        endcase
      end
    end

    // R9 commands, modulus writes and reads during busy are ignored
    mod_m = 64'(mod_of(4));
    wr(2'd2, mod_m[31:0]);
    b_m = 64'd12345;
    wr(2'd0, b_m[31:0]);
    rd(w);
    exp = mont(acc_m, b_m, mod_m);
    cmd(2'd2);
    cmd(2'd1);
    wr(2'd2, 32'h0000_0007);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == w, "R9 read ignored while busy", 64'(rd_data), 64'(w));
    wait_idle(n);
    read_result(v);
    chk(v == exp, "R9 result unaffected", v, exp);
    acc_m = exp;
    run_op(2'd2, "R9 modulus kept");

    chk(seen_ge_m, "R5 result at or above M delivered", 64'(seen_ge_m), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule